// File: doc/BRIEF.md
# Stack and Branch Sequencer

This unit settles the control-flow side of one instruction in a 16-bit word-addressed processor. It receives an opcode that an earlier stage has already decoded from the instruction stream. With it come the resolved operand, a count of words to discard on return, the current zero, sign and overflow flags, the sequential fall-through address and the current stack pointer. From these it produces the next instruction pointer and the next stack pointer. For stack operations it also makes one access on a single-port word memory. A pop or return hands the word it read back to the caller.

An operation starts with a one-cycle `start` pulse while the unit is idle. The unit reports completion with a one-cycle `done` pulse, and the results stay stable on the outputs until the next accepted start. The number of cycles is fixed for each class. Branches, jumps and unrecognised opcodes take one cycle. Pushes and calls take two: one write cycle, then completion. Pops and returns take three: a read request, a cycle for the memory data to arrive, then completion. The stack grows toward address 0. A push first moves the pointer down and then writes. A pop first reads and then moves the pointer up.

Top module: `flow_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_req` and `mem_we` are 0, and `ip_next`, `sp_next` and `pop_data` are 0.
- R2: Opcode 0x0A always loads `ip_next` with `operand`. `sp_next` equals `sp_in`, no memory access is made, and `done` is high in the first cycle after the clock edge that accepted `start`.
- R3: Conditional opcodes take `operand` when their condition holds and `ret_addr` otherwise. The conditions are: 0x0D zero clear; 0x0E zero set; 0x1A sign set; 0x1B sign clear; 0x0F sign equals overflow and zero clear; 0x10 sign equals overflow; 0x11 sign differs from overflow; 0x12 sign differs from overflow or zero set. Timing and `sp_next` are as in R2.
- R4: Any opcode other than 0x0A, 0x0D to 0x16 and 0x1A/0x1B gives `ip_next` = `ret_addr` and `sp_next` = `sp_in`. It makes no memory access and completes with R2 timing.
- R5: PUSH (0x13) writes `operand` at address `sp_in`-1 in the single cycle after the accepting edge, with `mem_req` and `mem_we` both high. `done` follows one cycle later, with `sp_next` = `sp_in`-1 and `ip_next` = `ret_addr`.
- R6: CALL (0x15) has the timing of R5, but it writes `ret_addr` at `sp_in`-1 and gives `ip_next` = `operand`.
- R7: POP (0x14) reads with `mem_req` high and `mem_we` low at address `sp_in` in the cycle after the accepting edge. It takes the word on `mem_rdata` in the following cycle. `done` comes one cycle after that, with `pop_data` equal to that word, `sp_next` = `sp_in`+1 and `ip_next` = `ret_addr`.
- R8: RET (0x16) has the timing of R7, with `ip_next` and `pop_data` equal to the word read and `sp_next` = `sp_in`+1+`ret_amount`. `ret_amount` is used only by RET, and `pop_data` is 0 after every operation that reads nothing.
- R9: Stack pointer arithmetic wraps modulo 2^16: a push at 0x0000 writes at 0xFFFF, and a pop at 0xFFFF leaves 0x0000.
- R10: `start` is ignored while `busy` is high. The running operation finishes with its own results, and no extra `done` follows.
- R11: `done` lasts exactly one cycle, and `mem_req` is high for exactly one cycle per stack operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opcode | input | 8 | Decoded opcode |
| operand | input | 16 | Branch target or value to push |
| ret_amount | input | 16 | Extra words discarded by a return (0 if absent) |
| ret_addr | input | 16 | Sequential fall-through address |
| sp_in | input | 16 | Current stack pointer |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_ovf | input | 1 | Overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ip_next | output | 16 | Next instruction pointer |
| sp_next | output | 16 | Next stack pointer |
| pop_data | output | 16 | Word read by a pop or return |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Read word, valid one cycle after a read request |

## Verification
A wrong condition decode appears at `ip_next` in the very first cycle after the accepting edge. It shows as the fall-through address where the target was due, or the reverse, for one specific flag pattern. A stack pointer that is off by one, or that does not wrap, shows on `mem_addr` during the access cycle, before `done` arrives. A wrong completion count shows as `done` a cycle early or late, or as a stale `pop_data` because the capture came before the memory data. A lost busy guard shows as a second `done` or as results replaced within the next cycle or two.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OPC_JUMP   = 8'h0A;
  localparam logic [OP_W-1:0] OPC_IFNZ   = 8'h0D;
  localparam logic [OP_W-1:0] OPC_IFZ    = 8'h0E;
  localparam logic [OP_W-1:0] OPC_IFGT   = 8'h0F;
  localparam logic [OP_W-1:0] OPC_IFGE   = 8'h10;
  localparam logic [OP_W-1:0] OPC_IFLT   = 8'h11;
  localparam logic [OP_W-1:0] OPC_IFLE   = 8'h12;
  localparam logic [OP_W-1:0] OPC_PUSH   = 8'h13;
  localparam logic [OP_W-1:0] OPC_POP    = 8'h14;
  localparam logic [OP_W-1:0] OPC_CALL   = 8'h15;
  localparam logic [OP_W-1:0] OPC_RET    = 8'h16;
  localparam logic [OP_W-1:0] OPC_IFNEG  = 8'h1A;
  localparam logic [OP_W-1:0] OPC_IFPOS  = 8'h1B;

  typedef enum logic [1:0] {
    K_FLOW  = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_ACCESS = 2'd1,
    S_WAIT   = 2'd2,
    S_FIN    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_seq_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic            zf,
  input  logic            sf,
  input  logic            vf,
  output op_kind_e        kind,
  output logic            take,
  output logic            is_call,
  output logic            is_ret
);

  logic sv_same;
  assign sv_same = (sf == vf);

  always_comb begin
    kind    = K_FLOW;
    take    = 1'b0;
    is_call = 1'b0;
    is_ret  = 1'b0;
    unique case (opcode)
      OPC_JUMP:  take = 1'b1;
      OPC_IFNZ:  take = !zf;
      OPC_IFZ:   take = zf;
      OPC_IFGT:  take = sv_same && !zf;
      OPC_IFGE:  take = sv_same;
      OPC_IFLT:  take = !sv_same;
      OPC_IFLE:  take = !sv_same || zf;
      OPC_IFNEG: take = sf;
      OPC_IFPOS: take = !sf;
      OPC_PUSH:  kind = K_WRITE;
      OPC_CALL:  begin kind = K_WRITE; is_call = 1'b1; end
      OPC_POP:   kind = K_READ;
      OPC_RET:   begin kind = K_READ; is_ret = 1'b1; end
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/flow_fsm.sv
module flow_fsm
  import flow_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_e kind_in,
  output logic     accept,
  output logic     busy,
  output logic     mem_req,
  output logic     mem_we,
  output logic     capture,
  output logic     done
);

  seq_state_e state, state_nx;
  op_kind_e   kind_q;

  assign accept  = start && (state == S_IDLE);
  assign busy    = (state != S_IDLE);
  assign mem_req = (state == S_ACCESS);
  assign mem_we  = mem_req && (kind_q == K_WRITE);
  assign capture = (state == S_WAIT);
  assign done    = (state == S_FIN);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:   if (accept) state_nx = (kind_in == K_FLOW) ? S_FIN : S_ACCESS;
      S_ACCESS: state_nx = (kind_q == K_READ) ? S_WAIT : S_FIN;
      S_WAIT:   state_nx = S_FIN;
      S_FIN:    state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= K_FLOW;
    end else begin
      state <= state_nx;
      if (accept) kind_q <= kind_in;
    end
  end

  // R11: completion never lasts more than one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a read request is always followed by the data-wait cycle
  p_read_then_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> capture);

  // R5: a write request is followed directly by completion
  p_write_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> done);

endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  input  logic [W-1:0]    operand,
  input  logic [W-1:0]    ret_amount,
  input  logic [W-1:0]    ret_addr,
  input  logic [W-1:0]    sp_in,
  input  logic            flag_zero,
  input  logic            flag_sign,
  input  logic            flag_ovf,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    ip_next,
  output logic [W-1:0]    sp_next,
  output logic [W-1:0]    pop_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] sp_after_push(input logic [W-1:0] sp);
    return sp - ONE;
  endfunction

  function automatic logic [W-1:0] sp_after_pop(input logic [W-1:0] sp,
                                                input logic [W-1:0] extra);
    return sp + ONE + extra;
  endfunction

  op_kind_e kind;
  logic     take, is_call, is_ret;
  logic     accept, capture;

  logic [W-1:0] ip_q, sp_q, pop_q, addr_q, wdata_q, amt_q;
  logic         ret_q;

  flow_decode u_dec (
    .opcode  (opcode),
    .zf      (flag_zero),
    .sf      (flag_sign),
    .vf      (flag_ovf),
    .kind    (kind),
    .take    (take),
    .is_call (is_call),
    .is_ret  (is_ret)
  );

  flow_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .kind_in (kind),
    .accept  (accept),
    .busy    (busy),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .capture (capture),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_q    <= '0;
      sp_q    <= '0;
      pop_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      amt_q   <= '0;
      ret_q   <= 1'b0;
    end else if (accept) begin
      pop_q <= '0;
      ret_q <= is_ret;
      amt_q <= '0;
      unique case (kind)
        K_WRITE: begin
          addr_q  <= sp_after_push(sp_in);
          sp_q    <= sp_after_push(sp_in);
          wdata_q <= is_call ? ret_addr : operand;
          ip_q    <= is_call ? operand : ret_addr;
        end
        K_READ: begin
          addr_q <= sp_in;
          amt_q  <= is_ret ? ret_amount : '0;
          sp_q   <= sp_after_pop(sp_in, is_ret ? ret_amount : '0);
          ip_q   <= ret_addr;
        end
        default: begin
          sp_q <= sp_in;
          ip_q <= take ? operand : ret_addr;
        end
      endcase
    end else if (capture) begin
      pop_q <= mem_rdata;
      if (ret_q) ip_q <= mem_rdata;
    end
  end

  assign ip_next   = ip_q;
  assign sp_next   = sp_q;
  assign pop_data  = pop_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R5: write enable only travels with a request
  p_we_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  // R5, R6: a write lands at the stack pointer the operation reports
  p_write_at_new_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == sp_next));

  // R8: after a read the reported pointer sits one word plus the discard above it
  p_read_below_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (sp_next - mem_addr - ONE == amt_q));

  // R11: one request cycle per stack operation
  p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10: a start during a running operation leaves its access address alone
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mem_addr));

endmodule

// File: tb/flow_seq_test.sv
module flow_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] operand = '0, ret_amount = '0, ret_addr = '0, sp_in = '0;
  logic        flag_zero = 1'b0, flag_sign = 1'b0, flag_ovf = 1'b0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] ip_next, sp_next, pop_data, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flow_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .operand(operand), .ret_amount(ret_amount), .ret_addr(ret_addr),
    .sp_in(sp_in), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_ovf(flag_ovf), .busy(busy), .done(done), .ip_next(ip_next),
    .sp_next(sp_next), .pop_data(pop_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] rd_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  // memory model: one cycle of read latency
  always @(posedge clk)
    if (mem_req && !mem_we) mem_rdata <= rd_word(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent restatement of the branch rules: signed less-than is s^v
  function automatic bit exp_take(input logic [7:0] op, input bit z, input bit s, input bit v);
    bit lt;
    lt = s ^ v;
    case (op)
      8'h0A: return 1;
      8'h0D: return z == 0;
      8'h0E: return z == 1;
      8'h0F: return !(lt || z);
      8'h10: return !lt;
      8'h11: return lt;
      8'h12: return lt || z;
      8'h1A: return s;
      8'h1B: return !s;
      default: return 0;
    endcase
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [15:0] opnd, input logic [15:0] amt,
                        input bit z, input bit s, input bit v,
                        input logic [15:0] ra, input logic [15:0] sp);
    int cyc, nreq, lat;
    bit req_we;
    logic [15:0] req_addr, req_wdata, e_ip, e_sp, e_pop, e_addr;
    bit is_push, is_pop;
    string t;
    opcode = op; operand = opnd; ret_amount = amt; ret_addr = ra; sp_in = sp;
    flag_zero = z; flag_sign = s; flag_ovf = v;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 1; nreq = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    while (!done && cyc < 8) begin
      if (mem_req) begin nreq++; req_we = mem_we; req_addr = mem_addr; req_wdata = mem_wdata; end
      @(posedge clk); #1;
      cyc++;
    end
    is_push = (op == 8'h13 || op == 8'h15);
    is_pop  = (op == 8'h14 || op == 8'h16);
    e_pop = '0;
    if (is_push) begin
      t = (op == 8'h15) ? "R6" : "R5";
      lat = 2; e_sp = sp - 16'd1; e_addr = e_sp;
      e_ip = (op == 8'h15) ? opnd : ra;
      chk({t, " write data"}, req_wdata, (op == 8'h15) ? ra : opnd);
      chk({t, " write enable"}, req_we, 1);
    end else if (is_pop) begin
      t = (op == 8'h16) ? "R8" : "R7";
      lat = 3; e_addr = sp; e_pop = rd_word(sp);
      e_sp = sp + 16'd1 + ((op == 8'h16) ? amt : 16'd0);
      e_ip = (op == 8'h16) ? e_pop : ra;
      chk({t, " read enable"}, req_we, 0);
    end else begin
      t = (op == 8'h0A) ? "R2" : (exp_take(op, 0, 0, 0) || exp_take(op, 1, 1, 1) ||
           exp_take(op, 0, 1, 0) || exp_take(op, 1, 0, 1)) ? "R3" : "R4";
      lat = 1; e_sp = sp; e_addr = '0;
      e_ip = exp_take(op, z, s, v) ? opnd : ra;
    end
    chk({t, " latency"}, cyc, lat);
    chk({t, " requests R11"}, nreq, (is_push || is_pop) ? 1 : 0);
    if (is_push || is_pop) chk({t, " address R9"}, req_addr, e_addr);
    chk({t, " ip_next"}, ip_next, e_ip);
    chk({t, " sp_next R9"}, sp_next, e_sp);
    chk({t, " pop_data"}, pop_data, e_pop);
    @(posedge clk); #1;
    chk({t, " done pulse R11"}, done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 ip_next", ip_next, 0);
    chk("R1 sp_next", sp_next, 0);
    chk("R1 pop_data", pop_data, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // sweep every opcode below 0x20 against all flag patterns
    for (int op = 0; op < 32; op++)
      for (int f = 0; f < 8; f++)
        run_op(8'(op), 16'h4000 + 16'(op * 16 + f), 16'(f * 3), f[0], f[1], f[2],
               16'h1000 + 16'(op), 16'h8000 + 16'(f * 7));
    run_op(8'hFF, 16'hBEEF, 16'd2, 1, 0, 1, 16'h2222, 16'h3333);   // R4
    run_op(8'h8A, 16'hBEEF, 16'd2, 0, 0, 0, 16'h2223, 16'h3334);   // R4

    // R9 wrap corners
    run_op(8'h13, 16'hAAAA, 16'd0, 0, 0, 0, 16'h0100, 16'h0000);
    run_op(8'h15, 16'h1234, 16'd0, 0, 0, 0, 16'h0101, 16'h0000);
    run_op(8'h14, 16'h0000, 16'd9, 0, 0, 0, 16'h0102, 16'hFFFF);
    run_op(8'h16, 16'h0000, 16'd0, 0, 0, 0, 16'h0103, 16'hFFFF);
    run_op(8'h16, 16'h0000, 16'h0020, 0, 0, 0, 16'h0104, 16'hFFF0);

    // R10: start while busy is ignored
    opcode = 8'h14; operand = '0; ret_amount = '0; ret_addr = 16'h0777; sp_in = 16'h0444;
    start = 1'b1;
    @(posedge clk); #1;
    opcode = 8'h0A; operand = 16'h9999; sp_in = 16'h0111;
    @(posedge clk); #1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R10 done on time", done, 1);
    chk("R10 ip kept", ip_next, 16'h0777);
    chk("R10 sp kept", sp_next, 16'h0445);
    chk("R10 pop kept", pop_data, rd_word(16'h0444));
    @(posedge clk); #1;
    chk("R10 no extra done", done, 0);
    @(posedge clk); #1;
    chk("R10 no extra done later", done, 0);
    chk("R10 idle", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule